// File: doc/BRIEF.md
# Four-Entry Instruction Translation Buffer with Pairwise LRU Replacement

This block is a small, fully associative instruction address translation buffer. It holds four page entries. Each entry has a virtual page number, a physical page number, a page size, an address-space tag, a shared flag and a user-access permission bit. A lookup address is compared against all four entries at once. A single match returns the entry index, the translated physical address and the permission bit in the same cycle. Two or more matches raise a multiple-hit fault and no index is reported.

Recency is tracked in a 6-bit pairwise least-recently-used word. The word corresponds to bits 31:26 of the enclosing control register, and software may reload it. A qualified lookup hit marks its entry as most recent. On a miss, the surrounding logic supplies a refill entry copied from the unified translation buffer. The block decodes the victim from the recency word, writes the new entry into that slot and marks the slot as most recent. When the overwritten slot held a valid page, the block asks for that old page to be invalidated. A recency pattern that names no victim is flagged as an error, and any refill offered in that state is dropped.

Top module: `itlb4_lru`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four entries become invalid, `lru_bits` becomes 6'b000000, and no lookup reports a hit afterwards.
- R2: An entry matches a lookup when three conditions hold. It is valid. Its page number equals the lookup page number above the page size. Its shared flag is set, or `lk_asid_en` is 0, or its tag equals `lk_asid`. A single match drives `lk_hit`=1 and `lk_idx` in the same cycle, and `lk_user_ok` follows the entry's permission bit.
- R3: Size code 0 means a 1 KiB page, 1 means 4 KiB, 2 means 64 KiB and 3 means 1 MiB. `lk_paddr` takes the physical page number above the page size and the lookup address bits below it.
- R4: When more than one entry matches, `lk_multi`=1 and `lk_hit`=0.
- R5: A lookup with `lk_valid`=1 that hits updates `lru_bits` at the next edge, as follows.
  - Entry 0 clears bits 5:3.
  - Entry 1 sets bit 5 and clears bits 2:1.
  - Entry 2 sets bits 4 and 2 and clears bit 0.
  - Entry 3 sets bits 3, 1 and 0.
- R6: `rf_victim` is chosen from `lru_bits` by these rules.
  - It is entry 0 if bits 5:3 are 111.
  - Otherwise it is entry 1 if bit 5 is 0 and bits 2:1 are 11.
  - Otherwise it is entry 2 if bits 4 and 2 are 0 and bit 0 is 1.
  - Otherwise it is entry 3 if bits 3, 1 and 0 are all 0.
- R7: A refill (`rf_valid`=1) writes the supplied fields into entry `rf_victim` as valid at the next edge and applies the R5 update for that entry.
- R8: `inval_req` is 1 during a refill exactly when the victim entry is valid. In that case `inval_vpn` carries the victim's old page number.
- R9: When `lru_bits` matches none of the R6 rules, `lru_err`=1. A refill offered then writes no entry, leaves `lru_bits` unchanged and raises no `inval_req`.
- R10: `lru_ld`=1 loads `lru_ld_val` into `lru_bits` at the next edge. It takes precedence over any hit or refill update in that cycle.
- R11: `ma_sel`, which corresponds to address bits 9:8 of array access, selects the entry shown on `ma_valid`, `ma_vpn` and `ma_asid`.
- R12: A lookup with `lk_valid`=0, a qualified lookup that misses, and a multiple-hit lookup all leave `lru_bits` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup is a real fetch; a hit updates recency |
| lk_vaddr | input | VPN_W+10 | Lookup virtual address |
| lk_asid_en | input | 1 | Address-space tag comparison enabled |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_idx | output | 2 | Index of the matching entry |
| lk_multi | output | 1 | Multiple-hit fault |
| lk_paddr | output | PPN_W+10 | Translated physical address (0 without a hit) |
| lk_user_ok | output | 1 | Matching entry permits user-mode fetch |
| rf_valid | input | 1 | Refill entry offered |
| rf_vpn | input | VPN_W | Refill virtual page number |
| rf_ppn | input | PPN_W | Refill physical page number |
| rf_asid | input | ASID_W | Refill address-space tag |
| rf_sz | input | 2 | Refill size code |
| rf_shared | input | 1 | Refill entry ignores the tag |
| rf_user_ok | input | 1 | Refill user-access permission |
| rf_victim | output | 2 | Entry the next refill will replace |
| inval_req | output | 1 | Refill displaces a valid page |
| inval_vpn | output | VPN_W | Page number to invalidate |
| lru_ld | input | 1 | Load the recency word |
| lru_ld_val | input | 6 | Value to load |
| lru_bits | output | 6 | Current recency word |
| lru_err | output | 1 | Recency word names no victim |
| ma_sel | input | 2 | Array view entry select |
| ma_valid | output | 1 | Selected entry valid |
| ma_vpn | output | VPN_W | Selected entry page number |
| ma_asid | output | ASID_W | Selected entry tag |

## Verification
The hardest state to reach from the ports is a recency word that names no victim. Hits and refills only ever move the word between patterns that decode to a victim, so normal traffic never produces it. The bench therefore uses the recency load to place the word on such a pattern, for example 6'b010001. It then offers a refill and checks three things through the array view and `lru_bits`: no entry changed, the word held its value, and no invalidation was requested. A multiple-hit condition is just as unreachable by normal refills of distinct pages. The bench creates it by refilling a 1 KiB page inside a 4 KiB page that is already resident.

// File: rtl/itlb_pkg.sv
// Shared constants and pure functions for the four-entry instruction TLB.
// Assumes exactly four entries: the recency encoding is defined for four.
package itlb_pkg;
    localparam int N_ENT  = 4;
    localparam int IDX_W  = 2;
    localparam int LRU_W  = 6;
    localparam int SZ_W   = 2;
    localparam int OFS_W  = 10;   // offset width of the smallest page
    localparam int SPAN_W = 10;   // extra offset bits of the largest page

    // Page-number bits that fall inside the page for a size code
    function automatic logic [SPAN_W-1:0] span_mask(input logic [SZ_W-1:0] sz);
        case (sz)
            2'd0:    return 10'h000;
            2'd1:    return 10'h003;
            2'd2:    return 10'h03F;
            default: return 10'h3FF;
        endcase
    endfunction

    // Recency word after marking one entry most recently used
    function automatic logic [LRU_W-1:0] lru_touch(input logic [LRU_W-1:0] cur,
                                                   input logic [IDX_W-1:0] idx);
        logic [LRU_W-1:0] nxt;
        nxt = cur;
        case (idx)
            2'd0: nxt[5:3] = 3'b000;
            2'd1: begin nxt[5] = 1'b1; nxt[2:1] = 2'b00; end
            2'd2: begin nxt[4] = 1'b1; nxt[2] = 1'b1; nxt[0] = 1'b0; end
            default: begin nxt[3] = 1'b1; nxt[1] = 1'b1; nxt[0] = 1'b1; end
        endcase
        return nxt;
    endfunction

    // Victim decode: returns {error, index}
    function automatic logic [IDX_W:0] lru_pick(input logic [LRU_W-1:0] l);
        if (l[5:3] == 3'b111)                return {1'b0, 2'd0};
        else if (!l[5] && l[2:1] == 2'b11)   return {1'b0, 2'd1};
        else if (!l[4] && !l[2] && l[0])     return {1'b0, 2'd2};
        else if (!l[3] && !l[1] && !l[0])    return {1'b0, 2'd3};
        else                                 return {1'b1, 2'd0};
    endfunction
endpackage

// File: rtl/itlb_lru_ctrl.sv
// Holds the 6-bit pairwise recency word and decodes the replacement victim.
// Assumes the caller resolves which entry (if any) is touched each cycle.
module itlb_lru_ctrl
    import itlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [LRU_W-1:0] ld_val,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [LRU_W-1:0] lru_q,
    output logic [IDX_W-1:0] victim,
    output logic             err
);
    // Recency register: load wins over touch
    always_ff @(posedge clk) begin
        if (!rst_n)     lru_q <= '0;
        else if (ld)    lru_q <= ld_val;
        else if (touch) lru_q <= lru_touch(lru_q, touch_idx);
    end

    // Victim and error decode from the current word
    assign {err, victim} = lru_pick(lru_q);
endmodule

// File: rtl/itlb_entry_store.sv
// Four translation entries with per-entry associative compare.
// Assumes VPN_W and PPN_W are at least SPAN_W; a write always makes the entry valid.
module itlb_entry_store
    import itlb_pkg::*;
#(
    parameter int VPN_W  = 22,
    parameter int PPN_W  = 19,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [SZ_W-1:0]   wr_sz,
    input  logic              wr_shared,
    input  logic              wr_user,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              lk_asid_en,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [N_ENT-1:0]  match,
    output logic [N_ENT-1:0]  ent_valid,
    output logic [N_ENT-1:0]  ent_user,
    output logic [VPN_W-1:0]  ent_vpn  [N_ENT],
    output logic [PPN_W-1:0]  ent_ppn  [N_ENT],
    output logic [ASID_W-1:0] ent_asid [N_ENT],
    output logic [SZ_W-1:0]   ent_sz   [N_ENT]
);
    localparam int HI_W = VPN_W - SPAN_W;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic              v_q, sh_q, usr_q;
        logic [SZ_W-1:0]   sz_q;
        logic [ASID_W-1:0] asid_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [PPN_W-1:0]  ppn_q;
        logic [VPN_W-1:0]  keep;
        logic              asid_ok;

        // Entry storage: cleared by reset, loaded on a refill aimed here
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q    <= 1'b0;
                sh_q   <= 1'b0;
                usr_q  <= 1'b0;
                sz_q   <= '0;
                asid_q <= '0;
                vpn_q  <= '0;
                ppn_q  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                v_q    <= 1'b1;
                sh_q   <= wr_shared;
                usr_q  <= wr_user;
                sz_q   <= wr_sz;
                asid_q <= wr_asid;
                vpn_q  <= wr_vpn;
                ppn_q  <= wr_ppn;
            end
        end

        assign keep     = {{HI_W{1'b1}}, ~span_mask(sz_q)};
        assign asid_ok  = sh_q || !lk_asid_en || (asid_q == lk_asid);
        assign match[g] = v_q && asid_ok && (((lk_vpn ^ vpn_q) & keep) == '0);

        assign ent_valid[g] = v_q;
        assign ent_user[g]  = usr_q;
        assign ent_vpn[g]   = vpn_q;
        assign ent_ppn[g]   = ppn_q;
        assign ent_asid[g]  = asid_q;
        assign ent_sz[g]    = sz_q;
    end
endmodule

// File: rtl/itlb_hit_sel.sv
// Resolves the match vector into hit, multiple-hit, index and physical address.
// Assumes PPN_W is at least SPAN_W; outputs are zero when there is no single hit.
module itlb_hit_sel
    import itlb_pkg::*;
#(
    parameter int PPN_W = 19
) (
    input  logic [N_ENT-1:0]        match,
    input  logic [PPN_W-1:0]        ent_ppn [N_ENT],
    input  logic [SZ_W-1:0]         ent_sz  [N_ENT],
    input  logic [N_ENT-1:0]        ent_user,
    input  logic [SPAN_W+OFS_W-1:0] ofs,
    output logic                    hit,
    output logic                    multi,
    output logic [IDX_W-1:0]        idx,
    output logic [PPN_W+OFS_W-1:0]  paddr,
    output logic                    user_ok
);
    logic [IDX_W:0]    n_match;
    logic [SPAN_W-1:0] sm;
    logic [PPN_W-1:0]  hi;

    // Count matches, pick the index and splice the physical address
    always_comb begin
        n_match = '0;
        idx     = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) begin
                n_match = n_match + 1'b1;
                idx     = IDX_W'(i);
            end
        end
        hit   = (n_match == 1);
        multi = (n_match > 1);
        sm    = span_mask(ent_sz[idx]);
        hi    = ent_ppn[idx];
        hi[SPAN_W-1:0] = (hi[SPAN_W-1:0] & ~sm) | (ofs[OFS_W +: SPAN_W] & sm);
        paddr   = hit ? {hi, ofs[OFS_W-1:0]} : '0;
        user_ok = hit && ent_user[idx];
    end
endmodule

// File: rtl/itlb4_lru.sv
// Four-entry fully associative instruction TLB with pairwise LRU refill.
// Lookup is combinational; refills and recency updates act on the next edge.
// Assumes the caller offers a refill only after a miss and handles invalidation.
module itlb4_lru
    import itlb_pkg::*;
#(
    parameter int VPN_W  = 22,
    parameter int PPN_W  = 19,
    parameter int ASID_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VPN_W+OFS_W-1:0] lk_vaddr,
    input  logic                   lk_asid_en,
    input  logic [ASID_W-1:0]      lk_asid,
    output logic                   lk_hit,
    output logic [IDX_W-1:0]       lk_idx,
    output logic                   lk_multi,
    output logic [PPN_W+OFS_W-1:0] lk_paddr,
    output logic                   lk_user_ok,
    input  logic                   rf_valid,
    input  logic [VPN_W-1:0]       rf_vpn,
    input  logic [PPN_W-1:0]       rf_ppn,
    input  logic [ASID_W-1:0]      rf_asid,
    input  logic [SZ_W-1:0]        rf_sz,
    input  logic                   rf_shared,
    input  logic                   rf_user_ok,
    output logic [IDX_W-1:0]       rf_victim,
    output logic                   inval_req,
    output logic [VPN_W-1:0]       inval_vpn,
    input  logic                   lru_ld,
    input  logic [LRU_W-1:0]       lru_ld_val,
    output logic [LRU_W-1:0]       lru_bits,
    output logic                   lru_err,
    input  logic [IDX_W-1:0]       ma_sel,
    output logic                   ma_valid,
    output logic [VPN_W-1:0]       ma_vpn,
    output logic [ASID_W-1:0]      ma_asid
);
    logic [N_ENT-1:0]  match, ent_valid, ent_user;
    logic [VPN_W-1:0]  ent_vpn  [N_ENT];
    logic [PPN_W-1:0]  ent_ppn  [N_ENT];
    logic [ASID_W-1:0] ent_asid [N_ENT];
    logic [SZ_W-1:0]   ent_sz   [N_ENT];
    logic              refill_go, touch;
    logic [IDX_W-1:0]  touch_idx;

    // Refill is accepted only when the recency word names a victim
    assign refill_go = rf_valid && !lru_err;
    assign touch     = refill_go || (lk_valid && lk_hit);
    assign touch_idx = refill_go ? rf_victim : lk_idx;

    itlb_lru_ctrl u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (lru_ld),
        .ld_val    (lru_ld_val),
        .touch     (touch),
        .touch_idx (touch_idx),
        .lru_q     (lru_bits),
        .victim    (rf_victim),
        .err       (lru_err)
    );

    itlb_entry_store #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (refill_go),
        .wr_idx     (rf_victim),
        .wr_vpn     (rf_vpn),
        .wr_ppn     (rf_ppn),
        .wr_asid    (rf_asid),
        .wr_sz      (rf_sz),
        .wr_shared  (rf_shared),
        .wr_user    (rf_user_ok),
        .lk_vpn     (lk_vaddr[VPN_W+OFS_W-1:OFS_W]),
        .lk_asid_en (lk_asid_en),
        .lk_asid    (lk_asid),
        .match      (match),
        .ent_valid  (ent_valid),
        .ent_user   (ent_user),
        .ent_vpn    (ent_vpn),
        .ent_ppn    (ent_ppn),
        .ent_asid   (ent_asid),
        .ent_sz     (ent_sz)
    );

    itlb_hit_sel #(.PPN_W(PPN_W)) u_sel (
        .match    (match),
        .ent_ppn  (ent_ppn),
        .ent_sz   (ent_sz),
        .ent_user (ent_user),
        .ofs      (lk_vaddr[SPAN_W+OFS_W-1:0]),
        .hit      (lk_hit),
        .multi    (lk_multi),
        .idx      (lk_idx),
        .paddr    (lk_paddr),
        .user_ok  (lk_user_ok)
    );

    // Displaced-page notice for the refill in flight
    assign inval_req = refill_go && ent_valid[rf_victim];
    assign inval_vpn = inval_req ? ent_vpn[rf_victim] : '0;

    // Array view of one entry
    assign ma_valid = ent_valid[ma_sel];
    assign ma_vpn   = ent_vpn[ma_sel];
    assign ma_asid  = ent_asid[ma_sel];
endmodule

// File: rtl/itlb4_lru_chk.sv
// Temporal checks on the TLB ports, bound into every instance of the top.
module itlb4_lru_chk
    import itlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic [IDX_W-1:0] lk_idx,
    input logic             lk_multi,
    input logic             rf_valid,
    input logic [IDX_W-1:0] rf_victim,
    input logic             inval_req,
    input logic             lru_ld,
    input logic [LRU_W-1:0] lru_ld_val,
    input logic [LRU_W-1:0] lru_bits,
    input logic             lru_err
);
    // R4
    multi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> !lk_hit);
    // R5
    touch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_hit && lk_idx == 2'd0 && !rf_valid && !lru_ld)
        |=> lru_bits[5:3] == 3'b000);
    // R5
    touch3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_hit && lk_idx == 2'd3 && !rf_valid && !lru_ld)
        |=> (lru_bits[3] && lru_bits[1] && lru_bits[0]));
    // R7
    refill2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !lru_err && !lru_ld && rf_victim == 2'd2)
        |=> (lru_bits[4] && lru_bits[2] && !lru_bits[0]));
    // R8
    inval_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_req |-> (rf_valid && !lru_err));
    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lru_err && !lru_ld && !(lk_valid && lk_hit)) |=> $stable(lru_bits));
    // R10
    ld_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lru_ld |=> lru_bits == $past(lru_ld_val));
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lru_ld && !rf_valid && !(lk_valid && lk_hit)) |=> $stable(lru_bits));
endmodule

bind itlb4_lru itlb4_lru_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_idx     (lk_idx),
    .lk_multi   (lk_multi),
    .rf_valid   (rf_valid),
    .rf_victim  (rf_victim),
    .inval_req  (inval_req),
    .lru_ld     (lru_ld),
    .lru_ld_val (lru_ld_val),
    .lru_bits   (lru_bits),
    .lru_err    (lru_err)
);

// File: tb/tb_itlb4_lru.sv
`timescale 1ns/1ps
module tb_itlb4_lru;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_asid_en;
    logic [31:0] lk_vaddr;
    logic [7:0]  lk_asid;
    logic        lk_hit, lk_multi, lk_user_ok;
    logic [1:0]  lk_idx;
    logic [28:0] lk_paddr;
    logic        rf_valid, rf_shared, rf_user_ok;
    logic [21:0] rf_vpn;
    logic [18:0] rf_ppn;
    logic [7:0]  rf_asid;
    logic [1:0]  rf_sz, rf_victim;
    logic        inval_req;
    logic [21:0] inval_vpn;
    logic        lru_ld, lru_err;
    logic [5:0]  lru_ld_val, lru_bits;
    logic [1:0]  ma_sel;
    logic        ma_valid;
    logic [21:0] ma_vpn;
    logic [7:0]  ma_asid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    itlb4_lru dut (.*);

    typedef struct packed {
        logic [31:0] va;
        logic        en;
        logic [7:0]  asid;
        logic        hit;
        logic [1:0]  idx;
        logic        multi;
        logic [28:0] pa;
        logic        user;
    } vec_t;

    // Lookups against the four resident pages (entry 3: 1K, 2: 1M shared, 1: 64K, 0: 4K)
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_4123, 1'b1, 8'h05, 1'b1, 2'd3, 1'b0, 29'h0004_0123, 1'b1},
        '{32'h0000_4123, 1'b1, 8'h06, 1'b0, 2'd0, 1'b0, 29'h0,         1'b0},
        '{32'h0000_4123, 1'b0, 8'h06, 1'b1, 2'd3, 1'b0, 29'h0004_0123, 1'b1},
        '{32'h0000_4523, 1'b0, 8'h05, 1'b0, 2'd0, 1'b0, 29'h0,         1'b0},
        '{32'h0000_8FFC, 1'b1, 8'h09, 1'b1, 2'd0, 1'b0, 29'h0000_9FFC, 1'b1},
        '{32'h0000_9000, 1'b1, 8'h09, 1'b0, 2'd0, 1'b0, 29'h0,         1'b0},
        '{32'h0002_ABCD, 1'b1, 8'h05, 1'b1, 2'd1, 1'b0, 29'h0011_ABCD, 1'b1},
        '{32'h0003_0000, 1'b1, 8'h05, 1'b0, 2'd0, 1'b0, 29'h0,         1'b0},
        '{32'h001A_BCDE, 1'b1, 8'h33, 1'b1, 2'd2, 1'b0, 29'h030A_BCDE, 1'b0},
        '{32'h0020_0000, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 29'h0,         1'b0},
        '{32'h000F_FFFF, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 29'h0,         1'b0},
        '{32'h001F_FFFF, 1'b1, 8'h00, 1'b1, 2'd2, 1'b0, 29'h030F_FFFF, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        lk_valid = 0; lk_asid_en = 0; lk_asid = 0; lk_vaddr = 0;
        rf_valid = 0; rf_vpn = 0; rf_ppn = 0; rf_asid = 0; rf_sz = 0;
        rf_shared = 0; rf_user_ok = 0; lru_ld = 0; lru_ld_val = 0; ma_sel = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic en, input logic [7:0] asid,
                        input logic qual);
        lk_vaddr = va; lk_asid_en = en; lk_asid = asid; lk_valid = qual;
        #1;
    endtask

    task automatic refill(input logic [21:0] vpn, input logic [18:0] ppn,
                          input logic [7:0] asid, input logic [1:0] sz, input logic sh,
                          input logic usr, input logic [1:0] exp_v, input logic exp_inv,
                          input logic [21:0] exp_ivpn, input string req);
        rf_valid = 1; rf_vpn = vpn; rf_ppn = ppn; rf_asid = asid; rf_sz = sz;
        rf_shared = sh; rf_user_ok = usr;
        #1;
        check(rf_victim == exp_v, req, 64'(rf_victim), 64'(exp_v));
        check(inval_req == exp_inv && (!exp_inv || inval_vpn == exp_ivpn), "R8",
              {inval_req, 22'(inval_vpn)}, {exp_inv, exp_ivpn});
        tick();
        rf_valid = 0;
        #1;
    endtask

    task automatic load_lru(input logic [5:0] v);
        lru_ld = 1; lru_ld_val = v;
        tick();
        lru_ld = 0;
        #1;
        check(lru_bits == v, "R10 load", 64'(lru_bits), 64'(v));
    endtask

    // Watchdog: a hung run counts as one failure
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        #1;
        // R1: reset state
        check(lru_bits == 6'b0, "R1 lru", 64'(lru_bits), 64'h0);
        look(32'h0000_4123, 1'b0, 8'h00, 1'b0);
        check(!lk_hit && !lk_multi, "R1 no hit", 64'({lk_hit, lk_multi}), 64'h0);
        for (int s = 0; s < 4; s++) begin
            ma_sel = 2'(s); #1;
            check(!ma_valid, "R1 entry invalid", 64'(ma_valid), 64'h0);
        end
        check(rf_victim == 2'd3 && !lru_err, "R6 reset victim", 64'(rf_victim), 64'h3);

        // R7: fill order 3,2,1,0 with no invalidation
        refill(22'h00010, 19'h00100, 8'h05, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0, 22'h0, "R7 fill3");
        refill(22'h00400, 19'h0C000, 8'h07, 2'd3, 1'b1, 1'b0, 2'd2, 1'b0, 22'h0, "R7 fill2");
        refill(22'h00080, 19'h00440, 8'h05, 2'd2, 1'b0, 1'b1, 2'd1, 1'b0, 22'h0, "R7 fill1");
        refill(22'h00020, 19'h00024, 8'h09, 2'd1, 1'b0, 1'b1, 2'd0, 1'b0, 22'h0, "R7 fill0");
        check(lru_bits == 6'b000000, "R7 lru after fills", 64'(lru_bits), 64'h0);
        // R11: array view by index
        ma_sel = 2'd3; #1;
        check(ma_valid && ma_vpn == 22'h10 && ma_asid == 8'h05, "R11 sel3",
              64'({ma_valid, ma_vpn, ma_asid}), 64'({1'b1, 22'h10, 8'h05}));
        ma_sel = 2'd1; #1;
        check(ma_valid && ma_vpn == 22'h80 && ma_asid == 8'h05, "R11 sel1",
              64'({ma_valid, ma_vpn, ma_asid}), 64'({1'b1, 22'h80, 8'h05}));

        // R2 R3: table of lookups, unqualified so recency stays put
        for (int k = 0; k < NV; k++) begin
            look(VEC[k].va, VEC[k].en, VEC[k].asid, 1'b0);
            if (VEC[k].hit)
                check(lk_hit && !lk_multi && lk_idx == VEC[k].idx && lk_paddr == VEC[k].pa
                      && lk_user_ok == VEC[k].user, "R2/R3 table hit",
                      {lk_hit, lk_multi, lk_idx, lk_paddr, lk_user_ok},
                      {1'b1, 1'b0, VEC[k].idx, VEC[k].pa, VEC[k].user});
            else
                check(!lk_hit && !lk_multi, "R2/R3 table miss",
                      64'({lk_hit, lk_multi}), 64'h0);
        end
        check(lru_bits == 6'b0, "R12 unqualified lookups", 64'(lru_bits), 64'h0);

        // R5: qualified hits update recency
        look(32'h0000_4123, 1'b1, 8'h05, 1'b1);
        tick(); lk_valid = 0; #1;
        check(lru_bits == 6'b001011, "R5 touch3", 64'(lru_bits), 64'h0B);
        check(rf_victim == 2'd2, "R6 after touch3", 64'(rf_victim), 64'h2);
        look(32'h0000_8FFC, 1'b1, 8'h09, 1'b1);
        tick(); lk_valid = 0; #1;
        check(lru_bits == 6'b000011, "R5 touch0", 64'(lru_bits), 64'h03);
        // R12: qualified miss leaves recency unchanged
        look(32'hFFFF_FFFF, 1'b0, 8'h00, 1'b1);
        tick(); lk_valid = 0; #1;
        check(lru_bits == 6'b000011, "R12 miss", 64'(lru_bits), 64'h03);

        // R6: decode of loaded patterns
        load_lru(6'b111000); check(rf_victim == 2'd0 && !lru_err, "R6 pick0", 64'(rf_victim), 64'h0);
        load_lru(6'b000110); check(rf_victim == 2'd1 && !lru_err, "R6 pick1", 64'(rf_victim), 64'h1);
        load_lru(6'b000001); check(rf_victim == 2'd2 && !lru_err, "R6 pick2", 64'(rf_victim), 64'h2);
        // R9: error pattern drops the refill
        load_lru(6'b010001);
        check(lru_err, "R9 err flag", 64'(lru_err), 64'h1);
        rf_valid = 1; rf_vpn = 22'h3FF; rf_ppn = 19'h1; rf_asid = 8'h01; rf_sz = 2'd0;
        #1;
        check(!inval_req, "R9 no inval", 64'(inval_req), 64'h0);
        tick(); rf_valid = 0; #1;
        check(lru_bits == 6'b010001, "R9 lru held", 64'(lru_bits), 64'h11);
        for (int s = 0; s < 4; s++) begin
            ma_sel = 2'(s); #1;
            check(ma_vpn != 22'h3FF, "R9 no entry written", 64'(ma_vpn), 64'h0);
        end

        // R8: overwrite valid entry 3 with a 1K page inside the 4K page of entry 0
        load_lru(6'b000000);
        refill(22'h00021, 19'h001F0, 8'h09, 2'd0, 1'b0, 1'b1, 2'd3, 1'b1, 22'h00010, "R7 overwrite");
        check(lru_bits == 6'b001011, "R7 lru after overwrite", 64'(lru_bits), 64'h0B);
        ma_sel = 2'd3; #1;
        check(ma_vpn == 22'h21 && ma_asid == 8'h09, "R11 new entry3",
              64'({ma_vpn, ma_asid}), 64'({22'h21, 8'h09}));

        // R4: overlapping pages give a multiple-hit, and do not touch recency
        look(32'h0000_8455, 1'b1, 8'h09, 1'b1);
        check(lk_multi && !lk_hit, "R4 multi", 64'({lk_multi, lk_hit}), 64'h2);
        tick(); lk_valid = 0; #1;
        check(lru_bits == 6'b001011, "R12 multi no touch", 64'(lru_bits), 64'h0B);
        look(32'h0000_8055, 1'b1, 8'h09, 1'b0);
        check(lk_hit && lk_idx == 2'd0 && lk_paddr == 29'h9055, "R2 single beside overlap",
              {lk_hit, lk_idx, lk_paddr}, {1'b1, 2'd0, 29'h9055});

        // R10: load wins over a same-cycle hit update
        lru_ld = 1; lru_ld_val = 6'b111000; lk_valid = 1;
        tick(); lru_ld = 0; lk_valid = 0; #1;
        check(lru_bits == 6'b111000, "R10 priority", 64'(lru_bits), 64'h38);

        // R1: reset mid-run clears everything
        rst_n = 0; tick(); rst_n = 1; #1;
        check(lru_bits == 6'b0, "R1 rerun lru", 64'(lru_bits), 64'h0);
        look(32'h0000_8055, 1'b1, 8'h09, 1'b0);
        check(!lk_hit && !lk_multi, "R1 rerun no hit", 64'({lk_hit, lk_multi}), 64'h0);
        ma_sel = 2'd0; #1;
        check(!ma_valid, "R1 rerun invalid", 64'(ma_valid), 64'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule